// File: doc/BRIEF.md
# Reload Down-Counter Timer on APB

This block is a 32-bit down-counter that sits on an APB slave port and occupies a 4 KB register window. Software arms it by loading a start or reload count, picks a tick source and turns it on. It then counts down once per tick. A tick is either every PCLK cycle, every PCLK cycle while an external pin is high (gated mode), or every rising edge of that pin (pin-clock mode). When the count steps from 1 to 0, a sticky interrupt flag is set, provided interrupts are enabled. The flag drives a level interrupt line. The count rests at 0 for one tick and then takes the reload value on the next tick.

The counter sequencing is a three-state machine:
- TS_STOP: the enable bit is clear and the count is frozen.
- TS_COUNT: the count decrements on each tick, or takes the reload value if it is already 0.
- TS_REST: the count is 0 for one tick after expiry.

Transitions:
- STOP→COUNT when the enable bit is set.
- COUNT→REST on the 1-to-0 tick.
- REST→COUNT on the next tick, which loads the reload value.
- Any state →STOP when the enable bit is cleared.
- A software write of the count forces COUNT, or STOP if the timer is disabled.

A read-only identification block sits at the top of the window.

Top module: `apb_reload_timer`

## Requirements
- R1: After reset, the control, count, reload and interrupt-flag registers all read 0 and `irq_o` is low.
- R2: The control register (offset 0x000) keeps only bits [3:0]; upper bits read 0. Bit 0 is the run enable; while it is 0 the count does not change.
- R3: With bits 1 and 2 of the control register clear, the count decrements on every PCLK. The interrupt flag is set on the edge where the count goes from 1 to 0, N cycles after the enabling write for a reload value N.
- R4: After reaching 0 the count holds 0 for one tick and loads the reload value on the next tick, so the interrupt repeats every N+1 ticks.
- R5: The flag is set on expiry only when control bit 3 is 1 at that moment.
- R6: With a reload value of 0, the count stays at 0 after expiry and no further interrupt is raised.
- R7: A write to the reload register (offset 0x008) sets both the reload value and the count. A write to the count register (offset 0x004) sets only the count.
- R8: Interrupt-flag bit 0 (offset 0x00C) is write-one-to-clear; writing 0 leaves it unchanged. `irq_o` equals that bit.
- R9: With control bit 1 set and bit 2 clear, the count decrements once per PCLK only while the synchronised `ext_in` is high.
- R10: With control bit 2 set, the count decrements once per rising edge of the synchronised `ext_in`, and bit 1 is then ignored.
- R11: Word offsets 0xFD0 to 0xFFC read, in ascending address order, 0x04, 0x00, 0x00, 0x00, 0x22, 0xB8, 0x1B, 0x00, 0x0D, 0xF0, 0x05, 0xB1. Writes to them are ignored.
- R12: Reads from any other offset return 0, and writes to them change nothing.
- R13: Every access completes without wait states and without an error response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Bus and counter clock |
| presetn | input | 1 | Active-low reset |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access phase |
| pwrite | input | 1 | 1 = write |
| paddr | input | 12 | Byte address within window |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data |
| pready | output | 1 | Always 1 |
| pslverr | output | 1 | Always 0 |
| ext_in | input | 1 | External gate or clock pin |
| irq_o | output | 1 | Level interrupt |

## Verification
The assertions assume that APB accesses follow the protocol: setup phase first, then exactly one access phase with stable address and data. They also assume `ext_in` holds each level for at least two PCLK cycles, so that the synchroniser sees every edge. The stimulus drives the bus only through tasks that build the two-phase transfer, and it toggles `ext_in` on falling clock edges with highs and lows of three cycles or more.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    localparam int DATA_W = 32;
    localparam int WORD_W = 10;

    localparam logic [WORD_W-1:0] W_CTRL   = 10'h000;
    localparam logic [WORD_W-1:0] W_COUNT  = 10'h001;
    localparam logic [WORD_W-1:0] W_RELOAD = 10'h002;
    localparam logic [WORD_W-1:0] W_FLAG   = 10'h003;
    localparam logic [WORD_W-1:0] W_ID_LO  = 10'h3F4;
    localparam logic [WORD_W-1:0] W_ID_HI  = 10'h3FF;

    localparam int CB_EN   = 0;
    localparam int CB_GATE = 1;
    localparam int CB_PCLK = 2;
    localparam int CB_IRQ  = 3;

    typedef enum logic [1:0] {
        TS_STOP  = 2'd0,
        TS_COUNT = 2'd1,
        TS_REST  = 2'd2
    } tmr_state_e;

    function automatic logic [7:0] id_byte(input logic [3:0] idx);
        logic [7:0] b;
        unique case (idx)
            4'd0:    b = 8'h04;
            4'd4:    b = 8'h22;
            4'd5:    b = 8'hB8;
            4'd6:    b = 8'h1B;
            4'd8:    b = 8'h0D;
            4'd9:    b = 8'hF0;
            4'd10:   b = 8'h05;
            4'd11:   b = 8'hB1;
            default: b = 8'h00;
        endcase
        return b;
    endfunction
endpackage

// File: rtl/tmr_ext_tick.sv
module tmr_ext_tick #(
    parameter int SYNC_STAGES = 2
) (
    input  logic pclk,
    input  logic presetn,
    input  logic ext_in,
    input  logic gate_sel,
    input  logic clk_sel,
    output logic tick_o
);
    localparam int LAST = SYNC_STAGES - 1;

    logic [LAST:0] sync_q;
    logic          prev_q;

    always_ff @(posedge pclk or negedge presetn) begin
        if (!presetn) begin
            sync_q[0] <= 1'b0;
        end else begin
            sync_q[0] <= ext_in;
        end
    end

    generate
        for (genvar g = 1; g < SYNC_STAGES; g++) begin : g_sync
            always_ff @(posedge pclk or negedge presetn) begin
                if (!presetn) begin
                    sync_q[g] <= 1'b0;
                end else begin
                    sync_q[g] <= sync_q[g-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge pclk or negedge presetn) begin
        if (!presetn) begin
            prev_q <= 1'b0;
        end else begin
            prev_q <= sync_q[LAST];
        end
    end

    always_comb begin
        if (clk_sel) begin
            tick_o = sync_q[LAST] & ~prev_q;
        end else if (gate_sel) begin
            tick_o = sync_q[LAST];
        end else begin
            tick_o = 1'b1;
        end
    end

    a_r10_edge_single: assert property (@(posedge pclk) disable iff (!presetn)
        (clk_sel && tick_o) |=> !(clk_sel && tick_o));
endmodule

// File: rtl/tmr_count_fsm.sv
module tmr_count_fsm
    import tmr_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             pclk,
    input  logic             presetn,
    input  logic             run_en,
    input  logic             tick,
    input  logic             load,
    input  logic [CNT_W-1:0] load_data,
    input  logic [CNT_W-1:0] reload,
    output logic [CNT_W-1:0] count_o,
    output logic             expire_o
);
    localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);
    localparam logic [CNT_W-1:0] ZERO = '0;

    tmr_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             expire;

    always_ff @(posedge pclk or negedge presetn) begin
        if (!presetn) begin
            state_q <= TS_STOP;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        expire  = 1'b0;
        if (load) begin
            cnt_d   = load_data;
            state_d = run_en ? TS_COUNT : TS_STOP;
        end else if (!run_en) begin
            state_d = TS_STOP;
        end else begin
            unique case (state_q)
                TS_STOP, TS_COUNT: begin
                    state_d = TS_COUNT;
                    if (tick) begin
                        if (cnt_q == ONE) begin
                            cnt_d   = ZERO;
                            expire  = 1'b1;
                            state_d = TS_REST;
                        end else if (cnt_q == ZERO) begin
                            cnt_d = reload;
                        end else begin
                            cnt_d = cnt_q - ONE;
                        end
                    end
                end
                TS_REST: begin
                    if (tick) begin
                        cnt_d   = reload;
                        state_d = TS_COUNT;
                    end
                end
                default: state_d = TS_STOP;
            endcase
        end
    end

    assign count_o  = cnt_q;
    assign expire_o = expire;

    a_r3_one_to_zero: assert property (@(posedge pclk) disable iff (!presetn)
        expire_o |=> (count_o == ZERO && state_q == TS_REST));
    a_r4_rest_reload: assert property (@(posedge pclk) disable iff (!presetn)
        (state_q == TS_REST && run_en && tick && !load) |=> (count_o == $past(reload)));
    a_r2_frozen_off: assert property (@(posedge pclk) disable iff (!presetn)
        (!run_en && !load) |=> $stable(count_o));
    a_r6_zero_silent: assert property (@(posedge pclk) disable iff (!presetn)
        (count_o == ZERO && state_q == TS_COUNT) |-> !expire_o);
endmodule

// File: rtl/tmr_regs.sv
module tmr_regs
    import tmr_pkg::*;
#(
    parameter int CNT_W  = 32,
    parameter int ADDR_W = 12
) (
    input  logic              pclk,
    input  logic              presetn,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [DATA_W-1:0] pwdata,
    input  logic [CNT_W-1:0]  count,
    input  logic              expire,
    output logic [DATA_W-1:0] prdata,
    output logic [3:0]        ctrl_o,
    output logic [CNT_W-1:0]  reload_o,
    output logic              load_o,
    output logic              flag_o
);
    logic [WORD_W-1:0] word;
    logic              wr;
    logic [3:0]        ctrl_q;
    logic [CNT_W-1:0]  reload_q;
    logic              flag_q;
    logic [3:0]        id_idx;

    assign word   = paddr[ADDR_W-1:2];
    assign wr     = psel & penable & pwrite;
    assign id_idx = 4'(word - W_ID_LO);

    always_ff @(posedge pclk or negedge presetn) begin
        if (!presetn) begin
            ctrl_q   <= '0;
            reload_q <= '0;
            flag_q   <= 1'b0;
        end else begin
            if (wr && word == W_CTRL) begin
                ctrl_q <= pwdata[3:0];
            end
            if (wr && word == W_RELOAD) begin
                reload_q <= pwdata[CNT_W-1:0];
            end
            if (expire && ctrl_q[CB_IRQ]) begin
                flag_q <= 1'b1;
            end else if (wr && word == W_FLAG && pwdata[0]) begin
                flag_q <= 1'b0;
            end
        end
    end

    always_comb begin
        prdata = '0;
        if (word == W_CTRL) begin
            prdata[3:0] = ctrl_q;
        end else if (word == W_COUNT) begin
            prdata[CNT_W-1:0] = count;
        end else if (word == W_RELOAD) begin
            prdata[CNT_W-1:0] = reload_q;
        end else if (word == W_FLAG) begin
            prdata[0] = flag_q;
        end else if (word >= W_ID_LO && word <= W_ID_HI) begin
            prdata[7:0] = id_byte(id_idx);
        end
    end

    assign ctrl_o   = ctrl_q;
    assign reload_o = reload_q;
    assign load_o   = wr && (word == W_COUNT || word == W_RELOAD);
    assign flag_o   = flag_q;

    a_r5_set_needs_en: assert property (@(posedge pclk) disable iff (!presetn)
        $rose(flag_q) |-> $past(expire && ctrl_q[CB_IRQ]));
    a_r8_w1c: assert property (@(posedge pclk) disable iff (!presetn)
        (wr && word == W_FLAG && pwdata[0] && !expire) |=> !flag_q);
    a_r8_hold: assert property (@(posedge pclk) disable iff (!presetn)
        (flag_q && !(wr && word == W_FLAG)) |=> flag_q);
endmodule

// File: rtl/apb_reload_timer.sv
module apb_reload_timer
    import tmr_pkg::*;
#(
    parameter int CNT_W       = 32,
    parameter int ADDR_W      = 12,
    parameter int SYNC_STAGES = 2
) (
    input  logic              pclk,
    input  logic              presetn,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [31:0]       pwdata,
    output logic [31:0]       prdata,
    output logic              pready,
    output logic              pslverr,
    input  logic              ext_in,
    output logic              irq_o
);
    logic [3:0]       ctrl;
    logic [CNT_W-1:0] reload, count;
    logic             load, expire, tick, flag;

    tmr_regs #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_regs (
        .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable),
        .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .count(count),
        .expire(expire), .prdata(prdata), .ctrl_o(ctrl), .reload_o(reload),
        .load_o(load), .flag_o(flag)
    );

    tmr_ext_tick #(.SYNC_STAGES(SYNC_STAGES)) u_tick (
        .pclk(pclk), .presetn(presetn), .ext_in(ext_in),
        .gate_sel(ctrl[CB_GATE]), .clk_sel(ctrl[CB_PCLK]), .tick_o(tick)
    );

    tmr_count_fsm #(.CNT_W(CNT_W)) u_fsm (
        .pclk(pclk), .presetn(presetn), .run_en(ctrl[CB_EN]), .tick(tick),
        .load(load), .load_data(pwdata[CNT_W-1:0]), .reload(reload),
        .count_o(count), .expire_o(expire)
    );

    assign pready  = 1'b1;
    assign pslverr = 1'b0;
    assign irq_o   = flag;

    a_r7_load_count: assert property (@(posedge pclk) disable iff (!presetn)
        (psel && penable && pwrite && paddr[ADDR_W-1:2] == W_RELOAD)
        |=> (count == $past(pwdata[CNT_W-1:0]) && reload == count));
endmodule

// File: tb/apb_reload_timer_tb_top.sv
module apb_reload_timer_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        pclk = 1'b0;
    logic        presetn = 1'b0;
    logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [11:0] paddr = '0;
    logic [31:0] pwdata = '0;
    logic [31:0] prdata;
    logic        pready, pslverr, ext_in = 1'b0, irq_o;
    int          cyc = 0;
    int          checks = 0, errors = 0;
    logic [31:0] rv;

    // reload N, expected cycles to first interrupt, expected period
    localparam int VEC[5][3] = '{'{2, 2, 3}, '{3, 3, 4}, '{5, 5, 6},
                                 '{9, 9, 10}, '{16, 16, 17}};
    localparam logic [7:0] IDV[12] = '{8'h04, 8'h00, 8'h00, 8'h00, 8'h22, 8'hB8,
                                      8'h1B, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};

    apb_reload_timer dut_i (
        .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable),
        .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
        .pready(pready), .pslverr(pslverr), .ext_in(ext_in), .irq_o(irq_o)
    );

    always #(CLK_PERIOD/2) pclk = ~pclk;
    always @(posedge pclk) cyc <= cyc + 1;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge pclk);
        psel = 1'b1; pwrite = 1'b1; paddr = a; pwdata = d; penable = 1'b0;
        @(negedge pclk);
        penable = 1'b1;
        @(posedge pclk);
        #1 psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge pclk);
        psel = 1'b1; pwrite = 1'b0; paddr = a; penable = 1'b0;
        @(negedge pclk);
        penable = 1'b1;
        #1 d = prdata;
        checks++;
        if (pready !== 1'b1 || pslverr !== 1'b0) begin
            errors++;
            $display("FAIL R13 actual=%b%b expected=10", pready, pslverr);
        end
        @(posedge pclk);
        #1 psel = 1'b0; penable = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge pclk);
    endtask

    task automatic wait_irq(output int when);
        when = -1;
        for (int k = 0; k < 400; k++) begin
            @(posedge pclk);
            #1;
            if (irq_o) begin
                when = cyc;
                break;
            end
        end
    endtask

    initial begin
        repeat (150000) @(posedge pclk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int t0, t1, t2;
        repeat (3) @(negedge pclk);
        presetn = 1'b1;

        // R1 reset state
        check("R1 irq", {31'b0, irq_o}, 32'h0);
        rd(12'h000, rv); check("R1 ctrl", rv, 0);
        rd(12'h004, rv); check("R1 count", rv, 0);
        rd(12'h008, rv); check("R1 reload", rv, 0);
        rd(12'h00C, rv); check("R1 flag", rv, 0);

        // R3 R4 table walk: latency and period
        for (int i = 0; i < 5; i++) begin
            wr(12'h000, 32'h0);
            wr(12'h00C, 32'h1);
            wr(12'h008, VEC[i][0]);
            wr(12'h000, 32'h9);
            t0 = cyc;
            wait_irq(t1);
            check("R3 latency", t1 - t0, VEC[i][1]);
            wr(12'h00C, 32'h1);
            wait_irq(t2);
            check("R4 period", t2 - t1, VEC[i][2]);
        end
        wr(12'h000, 32'h0);

        // R8 writing 0 keeps flag, writing 1 clears
        rd(12'h00C, rv); check("R8 flag set", rv, 1);
        wr(12'h00C, 32'h0);
        rd(12'h00C, rv); check("R8 write0 keeps", rv, 1);
        check("R8 irq level", {31'b0, irq_o}, 1);
        wr(12'h00C, 32'h1);
        rd(12'h00C, rv); check("R8 cleared", rv, 0);
        check("R8 irq low", {31'b0, irq_o}, 0);

        // R2 upper control bits dropped, frozen when off
        wr(12'h000, 32'hFFFF_FFF0);
        rd(12'h000, rv); check("R2 ctrl mask", rv, 0);
        wr(12'h008, 32'd40);
        idle(10);
        rd(12'h004, rv); check("R2 frozen", rv, 40);

        // R7 count write leaves reload
        wr(12'h008, 32'd9);
        wr(12'h004, 32'd4);
        rd(12'h008, rv); check("R7 reload kept", rv, 9);
        rd(12'h004, rv); check("R7 count set", rv, 4);

        // R5 no flag with bit 3 clear
        wr(12'h008, 32'd3);
        wr(12'h000, 32'h1);
        idle(12);
        rd(12'h00C, rv); check("R5 no flag", rv, 0);
        wr(12'h000, 32'h0);

        // R6 reload zero
        wr(12'h008, 32'd0);
        wr(12'h004, 32'd3);
        wr(12'h000, 32'h9);
        wait_irq(t1);
        check("R6 first irq", {31'b0, irq_o}, 1);
        wr(12'h00C, 32'h1);
        idle(20);
        rd(12'h00C, rv); check("R6 no repeat", rv, 0);
        rd(12'h004, rv); check("R6 stays zero", rv, 0);
        wr(12'h000, 32'h0);

        // R9 gated mode
        ext_in = 1'b0;
        wr(12'h008, 32'd100);
        wr(12'h000, 32'h3);
        idle(8);
        rd(12'h004, rv); check("R9 gate low holds", rv, 100);
        @(negedge pclk); ext_in = 1'b1;
        idle(10);
        ext_in = 1'b0;
        idle(6);
        rd(12'h004, rv); check("R9 gate counts", rv, 90);
        wr(12'h000, 32'h0);

        // R10 pin-clock mode
        wr(12'h008, 32'd10);
        wr(12'h000, 32'h5);
        idle(4);
        for (int p = 0; p < 3; p++) begin
            ext_in = 1'b1; idle(3);
            ext_in = 1'b0; idle(3);
        end
        idle(4);
        rd(12'h004, rv); check("R10 edges", rv, 7);
        wr(12'h000, 32'h0);
        // R10 overrides gate bit: steady high gives one tick
        wr(12'h008, 32'd50);
        wr(12'h000, 32'h7);
        idle(3);
        ext_in = 1'b1;
        idle(12);
        rd(12'h004, rv); check("R10 over gate", rv, 49);
        ext_in = 1'b0;
        wr(12'h000, 32'h0);

        // R11 identification
        for (int j = 0; j < 12; j++) begin
            rd(12'hFD0 + 12'(4*j), rv);
            check("R11 id", rv, {24'b0, IDV[j]});
        end
        wr(12'hFE0, 32'hFF);
        rd(12'hFE0, rv); check("R11 write ignored", rv, 32'h22);

        // R12 unmapped
        wr(12'h010, 32'hFFFF_FFFF);
        rd(12'h010, rv); check("R12 read zero", rv, 0);
        rd(12'h000, rv); check("R12 ctrl untouched", rv, 0);
        rd(12'h008, rv); check("R12 reload untouched", rv, 50);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule